// File: doc/BRIEF.md
# Four-Over-Six FP4 Block Scale Selector

This block turns a block of sixteen signed integer samples into sixteen 4-bit E2M1 codes and one 8-bit E4M3 scale. It tries two scales for every block. The first maps the largest magnitude in the block onto FP4 magnitude 6. The second maps it onto magnitude 4. Between FP4 magnitudes 4 and 6 the grid has a step of 2, so samples just below the block maximum can be poorly represented under the first scale. The second scale trades away headroom to place those samples on a finer part of the grid.

The block quantizes the whole block under each scale with round-to-nearest. It rebuilds the values, sums the squared reconstruction error of each candidate, and keeps the candidate with the smaller error. A valid/ready pair takes in whole blocks. A second valid/ready pair hands out the codes, the scale and a bit that names the winning candidate. Both candidates go through one shared bank of sixteen element quantizers, one after the other, so the output latency is fixed.

Top module: `fp4_scale_pick`

## Requirements
- R1: For divisor k (6 for the first candidate, 4 for the second), the candidate scale is the smallest positive E4M3 value whose product with k is at least the block's largest magnitude. The E4M3 layout is bit 7 sign (always 0), bits 6:3 exponent with bias 7, and bits 2:0 mantissa, with value 2^(e-7)*(1+m/8). A block of all zeros gives scale code 0x00.
- R2: Element i is `inData[8i+7:8i]` in two's complement, and its code is `outCodes[4i+3:4i]`. In the code, bit 3 is the sign, and bits 2:0 index the magnitudes 0, 0.5, 1, 1.5, 2, 3, 4, 6. The index chosen is the magnitude nearest to |x|/scale, and a tie goes to the larger magnitude. The sign bit is 0 whenever the index is 0.
- R3: The error of a candidate is the sum, over the 16 elements, of (|x| - magnitude*scale)^2. `outSel` is 1, naming the max/4 candidate, only when that candidate's error is strictly lower. Equal errors give `outSel` = 0, the max/6 candidate.
- R4: `outCodes` and `outScale` both come from the candidate that `outSel` names.
- R5: `inReady` is high only while no block is in flight. It drops in the cycle after a block is accepted.
- R6: After the rising edge that accepts a block, `outValid` stays low over the next edge and goes high right after the second edge. LATENCY = 2 edges.
- R7: While `outValid` is high and `outReady` is low, `outValid`, `outCodes`, `outScale` and `outSel` hold their values.
- R8: After reset, `outValid` is 0 and `inReady` is 1.
- R9: Changes on `inData` and `inValid` while `inReady` is low have no effect on the result being computed.
- R10: The edge that completes the output handshake drops `outValid` and raises `inReady`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input block offered |
| inReady | output | 1 | Block can be accepted |
| inData | input | NUM*DW | Sixteen signed samples, element i at bits DW*i upward |
| outValid | output | 1 | Result available |
| outReady | input | 1 | Consumer takes the result |
| outCodes | output | NUM*4 | E2M1 codes, element i at bits 4*i upward |
| outScale | output | 8 | E4M3 scale of the chosen candidate |
| outSel | output | 1 | 0 = max/6 candidate, 1 = max/4 candidate |

## Verification
The embedded assertions assume the following about the inputs:
- The consumer pulses `outReady` only while a result is waiting.
- `DW` is small enough that every scale is a normal E4M3 number. At the default width of 8, the largest scale is 32 and the smallest nonzero scale is above 1/6.
- `inValid` may stay high while the block is busy. Those cycles are where the assertions expect nothing to be accepted.

The stimulus keeps samples within the signed 8-bit range, including -128. It drops `inValid` at the point where the result appears, so that no block is accepted by accident. On some blocks it scrambles `inData` while the block is busy, to show that those changes have no effect.

// File: rtl/fp4sp_pkg.sv
package fp4sp_pkg;

  // Rising edges from the accepting edge until outValid is high.
  localparam int LATENCY = 2;

  typedef struct packed {
    logic load;       // capture the incoming block
    logic useFour;    // 0: divisor 6, 1: divisor 4
    logic capture;    // store the first candidate unconditionally
    logic challenge;  // store the second candidate if it is strictly better
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PASS6 = 2'd1,
    ST_PASS4 = 2'd2,
    ST_OUT   = 2'd3
  } ctrlState_t;

  // Midpoints between neighbouring FP4 magnitudes, in quarter units.
  function automatic logic [4:0] midQuarter(input int i);
    case (i)
      0:       return 5'd1;
      1:       return 5'd3;
      2:       return 5'd5;
      3:       return 5'd7;
      4:       return 5'd10;
      5:       return 5'd14;
      default: return 5'd20;
    endcase
  endfunction

  // FP4 magnitude for a 3-bit index, in half units.
  function automatic logic [3:0] gridHalf(input logic [2:0] idx);
    case (idx)
      3'd0:    return 4'd0;
      3'd1:    return 4'd1;
      3'd2:    return 4'd2;
      3'd3:    return 4'd3;
      3'd4:    return 4'd4;
      3'd5:    return 4'd6;
      3'd6:    return 4'd8;
      default: return 4'd12;
    endcase
  endfunction

endpackage

// File: rtl/fp4sp_lane.sv
module fp4sp_lane
  import fp4sp_pkg::*;
#(
  parameter int DW    = 8,
  parameter int SVW   = 17,
  parameter int DIFFW = 19
) (
  input  logic [DW-1:0]      mag,
  input  logic               neg,
  input  logic [SVW-1:0]     sVal,
  output logic [3:0]         code,
  output logic [2*DIFFW-1:0] sqErr
);
  localparam int CW = DW + SVW + 6;

  logic [CW-1:0] quad;
  logic [CW-1:0] twoX;
  logic [CW-1:0] recon;
  logic [CW-1:0] absDiff;
  logic [DIFFW-1:0] dShort;
  logic [2:0] idx;

  // Value domain: scale units of 2^-10, so quarters carry << 12 and halves << 11.
  assign quad = CW'(mag) << 12;
  assign twoX = CW'(mag) << 11;

  // The midpoints rise monotonically, so the number passed is the index.
  always_comb begin
    idx = '0;
    if (mag != '0) begin
      for (int i = 0; i < 7; i++) begin
        if (quad >= CW'(midQuarter(i)) * CW'(sVal)) idx = idx + 3'd1;
      end
    end
  end

  assign recon   = CW'(gridHalf(idx)) * CW'(sVal);
  assign absDiff = (twoX >= recon) ? (twoX - recon) : (recon - twoX);
  assign dShort  = DIFFW'(absDiff);
  assign sqErr   = (2*DIFFW)'(dShort) * (2*DIFFW)'(dShort);
  assign code    = {neg && (idx != 3'd0), idx};

endmodule

// File: rtl/fp4sp_datapath.sv
module fp4sp_datapath
  import fp4sp_pkg::*;
#(
  parameter int NUM = 16,
  parameter int DW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         strobe,
  input  logic [NUM*DW-1:0] inData,
  output logic [NUM*4-1:0]  outCodes,
  output logic [7:0]        outScale,
  output logic              outSel
);
  localparam int VW    = DW + 11;
  localparam int SVW   = DW + 9;
  localparam int DIFFW = DW + 11;
  localparam int SQW   = 2 * DIFFW;
  localparam int SUMW  = SQW + $clog2(NUM);

  logic [DW-1:0]   elem    [NUM];
  logic [DW-1:0]   magArr  [NUM];
  logic [SQW-1:0]  laneSq  [NUM];
  logic [NUM*4-1:0] laneCodes;
  logic [DW-1:0]   amax;
  logic [VW-1:0]   numer;
  logic [VW-1:0]   vCeil;
  logic [SVW-1:0]  sVal;
  logic [7:0]      scaleCode;
  logic [SUMW-1:0] errSum;
  logic [SUMW-1:0] errBest;
  logic [NUM*4-1:0] codesReg;
  logic [7:0]      scaleReg;
  logic            selReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM; i++) elem[i] <= '0;
    end else if (strobe.load) begin
      for (int i = 0; i < NUM; i++) elem[i] <= inData[i*DW +: DW];
    end
  end

  always_comb begin
    amax = '0;
    for (int i = 0; i < NUM; i++) begin
      if (magArr[i] > amax) amax = magArr[i];
    end
  end

  // Ceiling of amax / k in the 2^-10 domain.
  assign numer = VW'({amax, 10'b0});
  assign vCeil = strobe.useFour ? (numer >> 2) : ((numer + VW'(5)) / VW'(6));

  // Round vCeil up to the next value of the form (8+m) << e.
  always_comb begin
    int msb;
    int ex;
    logic [4:0] mant;
    logic [VW-1:0] lowMask;
    msb = 0;
    for (int b = 0; b < VW; b++) begin
      if (vCeil[b]) msb = b;
    end
    ex      = (msb >= 3) ? (msb - 3) : 0;
    lowMask = (VW'(1) << ex) - VW'(1);
    mant    = 5'(vCeil >> ex);
    if ((vCeil & lowMask) != '0) mant = mant + 5'd1;
    if (mant == 5'd16) begin
      mant = 5'd8;
      ex   = ex + 1;
    end
    if (vCeil == '0) begin
      scaleCode = 8'h00;
      sVal      = '0;
    end else begin
      scaleCode = {1'b0, ex[3:0], mant[2:0]};
      sVal      = SVW'(mant) << ex;
    end
  end

  for (genvar g = 0; g < NUM; g++) begin : gLane
    assign magArr[g] = elem[g][DW-1] ? (~elem[g] + 1'b1) : elem[g];

    fp4sp_lane #(.DW(DW), .SVW(SVW), .DIFFW(DIFFW)) lane_i (
      .mag   (magArr[g]),
      .neg   (elem[g][DW-1]),
      .sVal  (sVal),
      .code  (laneCodes[g*4 +: 4]),
      .sqErr (laneSq[g])
    );
  end

  always_comb begin
    errSum = '0;
    for (int i = 0; i < NUM; i++) errSum = errSum + SUMW'(laneSq[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      codesReg <= '0;
      scaleReg <= '0;
      selReg   <= 1'b0;
      errBest  <= '0;
    end else if (strobe.capture) begin
      codesReg <= laneCodes;
      scaleReg <= scaleCode;
      selReg   <= 1'b0;
      errBest  <= errSum;
    end else if (strobe.challenge && (errSum < errBest)) begin
      codesReg <= laneCodes;
      scaleReg <= scaleCode;
      selReg   <= 1'b1;
      errBest  <= errSum;
    end
  end

  assign outCodes = codesReg;
  assign outScale = scaleReg;
  assign outSel   = selReg;

  // R1: the chosen scale times its divisor reaches the block maximum.
  a_r1_scale_covers: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.capture || strobe.challenge) |->
      ((VW+4)'(sVal) * (VW+4)'(strobe.useFour ? 4 : 6) >= (VW+4)'({amax, 10'b0})));

endmodule

// File: rtl/fp4sp_ctrl.sv
module fp4sp_ctrl
  import fp4sp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      inValid,
  input  logic      outReady,
  output logic      inReady,
  output logic      outValid,
  output dpStrobe_t strobe
);
  ctrlState_t state;
  ctrlState_t nextState;

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:  if (inValid) nextState = ST_PASS6;
      ST_PASS6: nextState = ST_PASS4;
      ST_PASS4: nextState = ST_OUT;
      default:  if (outReady) nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  assign inReady          = (state == ST_IDLE);
  assign outValid         = (state == ST_OUT);
  assign strobe.load      = (state == ST_IDLE) && inValid;
  assign strobe.useFour   = (state == ST_PASS4);
  assign strobe.capture   = (state == ST_PASS6);
  assign strobe.challenge = (state == ST_PASS4);

  // R5: one block per handshake
  a_r5_one_block: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady) |=> !inReady);

  // R6: no result before the second edge
  a_r6_not_early: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady) |=> !outValid ##1 !outValid);

  // R6: result present after the second edge
  a_r6_on_time: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady) |-> ##3 outValid);

  // R10: handshake releases the block
  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outReady) |=> (!outValid && inReady));

endmodule

// File: rtl/fp4_scale_pick.sv
module fp4_scale_pick
  import fp4sp_pkg::*;
#(
  parameter int NUM = 16,
  parameter int DW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  output logic              inReady,
  input  logic [NUM*DW-1:0] inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [NUM*4-1:0]  outCodes,
  output logic [7:0]        outScale,
  output logic              outSel
);
  dpStrobe_t strobe;

  fp4sp_ctrl ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  fp4sp_datapath #(.NUM(NUM), .DW(DW)) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .inData   (inData),
    .outCodes (outCodes),
    .outScale (outScale),
    .outSel   (outSel)
  );

  // R7: a waiting result does not move
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=>
      (outValid && $stable(outCodes) && $stable(outScale) && $stable(outSel)));

endmodule

// File: tb/fp4_scale_pick_tb_top.sv
`timescale 1ns/1ps
module fp4_scale_pick_tb_top;
  localparam int NUM = 16;
  localparam int DW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [NUM*DW-1:0] inData = '0;
  logic outValid;
  logic outReady = 1'b0;
  logic [NUM*4-1:0] outCodes;
  logic [7:0] outScale;
  logic outSel;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  fp4_scale_pick #(.NUM(NUM), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outCodes(outCodes),
    .outScale(outScale), .outSel(outSel)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic real e4m3Val(input int c);
    int e;
    int m;
    e = (c >> 3) & 15;
    m = c & 7;
    if (e == 0) return (m / 8.0) * (2.0 ** (-6));
    return (2.0 ** (e - 7)) * (1.0 + m / 8.0);
  endfunction

  function automatic real gridVal(input int j);
    case (j)
      0: return 0.0;
      1: return 0.5;
      2: return 1.0;
      3: return 1.5;
      4: return 2.0;
      5: return 3.0;
      6: return 4.0;
      default: return 6.0;
    endcase
  endfunction

  task automatic modelCand(input logic [NUM*DW-1:0] d, input int k,
                           output logic [63:0] codes, output int sc, output real err);
    int amax;
    real s;
    amax = 0;
    codes = '0;
    err = 0.0;
    for (int i = 0; i < NUM; i++) begin
      int v;
      v = int'($signed(d[i*DW +: DW]));
      if (v < 0) v = -v;
      if (v > amax) amax = v;
    end
    sc = 0;
    if (amax > 0) begin
      for (int c = 1; c < 127; c++) begin
        if (sc == 0 && e4m3Val(c) * k >= amax) sc = c;
      end
    end
    s = (sc == 0) ? 0.0 : e4m3Val(sc);
    for (int i = 0; i < NUM; i++) begin
      int v;
      real a;
      real bd;
      int best;
      v = int'($signed(d[i*DW +: DW]));
      a = (v < 0) ? -v : v;
      best = 0;
      bd = a;
      if (s > 0.0) begin
        for (int j = 1; j < 8; j++) begin
          real dd;
          dd = a - gridVal(j) * s;
          if (dd < 0.0) dd = -dd;
          if (dd <= bd) begin
            bd = dd;
            best = j;
          end
        end
      end
      codes[i*4 +: 4] = {(v < 0 && best != 0), 3'(best)};
      err = err + (a - gridVal(best) * s) * (a - gridVal(best) * s);
    end
  endtask

  task automatic runBlock(input logic [NUM*DW-1:0] d, input int hold, input bit garbage);
    logic [63:0] c6, c4, expCodes;
    int s6, s4, expScale;
    real e6, e4;
    bit expSel;
    logic [63:0] gotCodes;
    logic [7:0] gotScale;
    logic gotSel;
    modelCand(d, 6, c6, s6, e6);
    modelCand(d, 4, c4, s4, e4);
    expSel = (e4 < e6);
    expCodes = expSel ? c4 : c6;
    expScale = expSel ? s4 : s6;

    @(negedge clk);
    inData = d;
    inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    if (garbage) inData = {$urandom(), $urandom(), $urandom(), $urandom()};
    chk(!inReady, "R5 inReady low after accept", 64'(inReady), 64'd0);
    chk(!outValid, "R6 outValid low after first edge", 64'(outValid), 64'd0);
    @(negedge clk);
    if (garbage) inData = {$urandom(), $urandom(), $urandom(), $urandom()};
    chk(!outValid, "R6 outValid low after second edge", 64'(outValid), 64'd0);
    @(negedge clk);
    inValid = 1'b0;
    chk(outValid, "R6 outValid high after third edge", 64'(outValid), 64'd1);
    chk(outScale == 8'(expScale), "R1 scale (R4 candidate)", 64'(outScale), 64'(expScale));
    chk(outCodes == expCodes, "R2 element codes (R4 candidate)", outCodes, expCodes);
    chk(outSel == expSel, "R3 select bit", 64'(outSel), 64'(expSel));
    if (garbage)
      chk(outCodes == expCodes && outScale == 8'(expScale) && outSel == expSel,
          "R9 busy-time input ignored", {outSel, outScale, outCodes[54:0]},
          {expSel, 8'(expScale), expCodes[54:0]});
    gotCodes = outCodes;
    gotScale = outScale;
    gotSel = outSel;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(outValid && outCodes == gotCodes && outScale == gotScale && outSel == gotSel,
          "R7 hold under backpressure", {outValid, outCodes[62:0]}, {1'b1, gotCodes[62:0]});
    end
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    chk(!outValid && inReady, "R10 release after handshake",
        {62'd0, outValid, inReady}, 64'd1);
  endtask

  function automatic logic [NUM*DW-1:0] randBlock();
    logic [NUM*DW-1:0] d;
    int amp;
    amp = $urandom_range(128, 1);
    for (int i = 0; i < NUM; i++) begin
      int v;
      v = int'($urandom_range(2 * amp, 0)) - amp;
      if ($urandom_range(7, 0) == 0) v = ($urandom_range(1, 0) == 1) ? amp : -amp;
      if (v > 127) v = 127;
      if (v < -128) v = -128;
      d[i*DW +: DW] = 8'(v);
    end
    return d;
  endfunction

  initial begin
    logic [NUM*DW-1:0] d;
    void'($urandom(32'h5eed_0046));
    repeat (3) @(negedge clk);
    chk(!outValid, "R8 outValid after reset", 64'(outValid), 64'd0);
    chk(inReady, "R8 inReady after reset", 64'(inReady), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // all-zero block: scale 0x00, codes 0, select 0
    runBlock('0, 0, 1'b0);
    // single value 12: both candidates exact, tie keeps max/6
    d = '0; d[5*DW +: DW] = 8'd12;
    runBlock(d, 2, 1'b0);
    // most negative sample
    d = '0; d[0 +: DW] = 8'h80; d[DW +: DW] = 8'd100; d[2*DW +: DW] = 8'hC3;
    runBlock(d, 1, 1'b1);
    // values just under the maximum: max/4 should win
    for (int i = 0; i < NUM; i++) d[i*DW +: DW] = (i == 0) ? 8'd6 : 8'd5;
    runBlock(d, 0, 1'b0);
    // midpoint ties: 6 then 1.0-scale half points
    for (int i = 0; i < NUM; i++) d[i*DW +: DW] = 8'(i % 7);
    runBlock(d, 3, 1'b1);

    for (int n = 0; n < 300; n++) begin
      runBlock(randBlock(), int'($urandom_range(3, 0)), n[0]);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule